// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns a simple synchronous request port into the strobe sequences of an asynchronous DRAM whose row and column addresses share one group of address pins. A request carries a full address, write data and a read/write flag. It is taken with a valid/ready handshake. The controller places the upper half of the address on the pins and lowers the row strobe. After a programmable delay it places the lower half on the pins and lowers the column strobe. For a write it also lowers the write-enable strobe and drives the write data. For a read it captures the data the device returns.

The row stays open after an access. A later request to the same row reuses it with a column strobe pulse only, which is page mode. A request to a different row first raises the row strobe for a programmable precharge time. A refresh timer derives its period from a retention window divided by the number of rows. When a refresh is due, the controller takes it at the next idle point. It closes any open row, then runs a row-strobe-only cycle on a rolling refresh row counter.

Top module: `dram_page_ctrl`

## Requirements
- R1: During and right after reset, dramRasN, dramCasN and dramWeN are high, rspValid is low, reqReady is high, and no row is open, so the first access opens a row.
- R2: The row half reqAddr[2*PIN_W-1:PIN_W] is on dramAddr when dramRasN falls. The column half reqAddr[PIN_W-1:0] is on dramAddr when dramCasN falls.
- R3: On a row-opening access, dramCasN falls at least T_RCD cycles after dramRasN falls. Every column pulse keeps dramCasN low for exactly T_CAS cycles, and dramCasN falls only while dramRasN is low.
- R4: A write drives dramDin and holds dramWeN low only while dramCasN is low. A read keeps dramWeN high and returns the device data on rspData with a one-cycle rspValid pulse.
- R5: A request whose row equals the open row keeps dramRasN low and issues only a column pulse. rspValid rises T_CAS+2 cycles after the accepting edge. For comparison, a request to a closed row takes T_RCD+T_CAS+2 cycles.
- R6: dramRasN stays high for at least T_PRE cycles before every fall. A request that misses the open row therefore takes T_PRE+T_RCD+T_CAS+2 cycles to rspValid.
- R7: reqReady goes low on the cycle after a request is accepted. It stays low until the access has completed, and also while a refresh is due or running.
- R8: A refresh is due every REF_WINDOW_CYC / 2**PIN_W cycles. It is a cycle with the row strobe only: dramRasN is low for T_RCD+T_CAS cycles while dramCasN stays high.
- R9: Refresh cycles present refresh row addresses 0, 1, 2, ... on dramAddr, and the count wraps from 2**PIN_W-1 to 0.
- R10: A refresh closes the open row, so the next access to that row pays the closed-row latency of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on an edge where both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 2*PIN_W | Full address, row half on top |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | DATA_W | Read data |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramAddr | output | PIN_W | Multiplexed row/column address pins |
| dramDin | output | DATA_W | Data to the device |
| dramDout | input | DATA_W | Data from the device |

## Verification
Suppose the open-row tag holds a stale row. A request would then be treated as a page hit. Within T_CAS+2 cycles of the accept, the wrong data would appear on rspData, dramRasN would fail to toggle, and the latency would be shorter than expected. A timing counter that is off by one shows at the pins on the very next strobe edge, as a wrong column-pulse width, a short precharge gap or a short row-to-column gap. A refresh flag that sticks or is lost shows within one refresh interval, as reqReady held low, a missing refresh cycle or a skipped refresh row address.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [1:0] {
    ADDR_HOLD,
    ADDR_ROW,
    ADDR_COL,
    ADDR_REF
  } addrSel_e;

  typedef struct packed {
    logic     rasLow;
    logic     casLow;
    logic     weLow;
    logic     capture;
    logic     loadReq;
    addrSel_e addrSel;
  } dramStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ROW,
    S_COL,
    S_CUP,
    S_RCLOSE,
    S_RROW,
    S_RPOST
  } ctrlState_e;

endpackage

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_W        = 8,
  parameter int T_PRE        = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int REF_INTERVAL = 62500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PIN_W-1:0]  reqRow,
  output logic              reqReady,
  output dramStrobe_t       strobes,
  output logic [PIN_W-1:0]  refRow
);

  localparam int MAX_DUR = T_PRE + T_RCD + T_CAS;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL + 1);

  ctrlState_e       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refTmr;
  logic             refPending;
  logic             rowOpen;
  logic [PIN_W-1:0] openRow;
  logic [PIN_W-1:0] curRow;
  logic             isWrite;
  logic             accept;
  logic             pageHit;

  function automatic logic [CNT_W-1:0] durOf(ctrlState_e s);
    case (s)
      S_PRE, S_RCLOSE, S_RPOST: durOf = CNT_W'(T_PRE - 1);
      S_ROW:                    durOf = CNT_W'(T_RCD - 1);
      S_COL:                    durOf = CNT_W'(T_CAS - 1);
      S_RROW:                   durOf = CNT_W'(T_RCD + T_CAS - 1);
      default:                  durOf = '0;
    endcase
  endfunction

  assign reqReady = (state == S_IDLE) && !refPending;
  assign accept   = reqValid && reqReady;
  assign pageHit  = rowOpen && (reqRow == openRow);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: begin
        if (refPending)  nxt = rowOpen ? S_RCLOSE : S_RROW;
        else if (accept) nxt = pageHit ? S_COL : (rowOpen ? S_PRE : S_ROW);
      end
      S_PRE:    if (cnt == '0) nxt = S_ROW;
      S_ROW:    if (cnt == '0) nxt = S_COL;
      S_COL:    if (cnt == '0) nxt = S_CUP;
      S_CUP:    nxt = S_IDLE;
      S_RCLOSE: if (cnt == '0) nxt = S_RROW;
      S_RROW:   if (cnt == '0) nxt = S_RPOST;
      S_RPOST:  if (cnt == '0) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.addrSel = ADDR_HOLD;
    case (state)
      S_IDLE: begin
        strobes.rasLow  = rowOpen;
        strobes.loadReq = accept;
      end
      S_ROW: begin
        strobes.rasLow  = 1'b1;
        strobes.addrSel = ADDR_ROW;
      end
      S_COL: begin
        strobes.rasLow  = 1'b1;
        strobes.casLow  = 1'b1;
        strobes.weLow   = isWrite;
        strobes.addrSel = ADDR_COL;
      end
      S_CUP: begin
        strobes.rasLow  = 1'b1;
        strobes.capture = !isWrite;
      end
      S_RROW: begin
        strobes.rasLow  = 1'b1;
        strobes.addrSel = ADDR_REF;
      end
      default: strobes.rasLow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      refTmr     <= '0;
      refPending <= 1'b0;
      rowOpen    <= 1'b0;
      openRow    <= '0;
      curRow     <= '0;
      isWrite    <= 1'b0;
      refRow     <= '0;
    end else begin
      state <= nxt;
      if (state != nxt)     cnt <= durOf(nxt);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);

      if (accept) begin
        curRow  <= reqRow;
        isWrite <= reqWrite;
      end

      if (state == S_CUP) begin
        rowOpen <= 1'b1;
        openRow <= curRow;
      end else if (state == S_PRE || state == S_RCLOSE || state == S_RROW) begin
        rowOpen <= 1'b0;
      end

      if (state == S_RROW && cnt == '0) refRow <= refRow + 1'b1;

      if (state == S_RROW) refPending <= 1'b0;
      if (refTmr == REF_W'(REF_INTERVAL - 1)) begin
        refTmr     <= '0;
        refPending <= 1'b1;
      end else begin
        refTmr <= refTmr + REF_W'(1);
      end
    end
  end

  // R7: an accepted request makes the port busy on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

endmodule

// File: rtl/dram_ctrl_datapath.sv
module dram_ctrl_datapath
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 8,
  parameter int T_PRE  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dramStrobe_t          strobes,
  input  logic [2*PIN_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [PIN_W-1:0]     refRow,
  input  logic [DATA_W-1:0]    dramDout,
  output logic                 dramRasN,
  output logic                 dramCasN,
  output logic                 dramWeN,
  output logic [PIN_W-1:0]     dramAddr,
  output logic [DATA_W-1:0]    dramDin,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspData
);

  localparam int RUN_W = $clog2(T_PRE + 1) + 1;

  logic [PIN_W-1:0]  rowQ, colQ;
  logic [DATA_W-1:0] wdataQ;
  logic [RUN_W-1:0]  rasHighRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      wdataQ   <= '0;
      dramRasN <= 1'b1;
      dramCasN <= 1'b1;
      dramWeN  <= 1'b1;
      dramAddr <= '0;
      dramDin  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobes.loadReq) begin
        rowQ   <= reqAddr[2*PIN_W-1:PIN_W];
        colQ   <= reqAddr[PIN_W-1:0];
        wdataQ <= reqWdata;
      end
      dramRasN <= !strobes.rasLow;
      dramCasN <= !strobes.casLow;
      dramWeN  <= !(strobes.weLow && strobes.casLow);
      case (strobes.addrSel)
        ADDR_ROW: dramAddr <= rowQ;
        ADDR_COL: dramAddr <= colQ;
        ADDR_REF: dramAddr <= refRow;
        default:  dramAddr <= dramAddr;
      endcase
      if (strobes.casLow) dramDin <= wdataQ;
      rspValid <= strobes.capture;
      if (strobes.capture) rspData <= dramDout;
    end
  end

  // Precharge-gap tracker used only by the R6 property
  always_ff @(posedge clk) begin
    if (!rstN)                          rasHighRun <= RUN_W'(T_PRE);
    else if (dramRasN == 1'b0)          rasHighRun <= '0;
    else if (rasHighRun < RUN_W'(T_PRE)) rasHighRun <= rasHighRun + RUN_W'(1);
  end

  // R6: row strobe falls only after a full precharge gap
  a_r6_precharge_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (rasHighRun >= RUN_W'(T_PRE)));

  // R3: column strobe falls only inside an open row
  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> !dramRasN);

  // R4: write enable never low outside a column pulse
  a_r4_we_with_cas: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> !dramCasN);

  // R4: read data is captured while the column strobe is still low
  a_r4_capture_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !dramCasN);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_W          = 8,
  parameter int DATA_W         = 8,
  parameter int T_PRE          = 2,
  parameter int T_RCD          = 2,
  parameter int T_CAS          = 2,
  parameter int REF_WINDOW_CYC = 16_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [2*PIN_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspData,
  output logic                 dramRasN,
  output logic                 dramCasN,
  output logic                 dramWeN,
  output logic [PIN_W-1:0]     dramAddr,
  output logic [DATA_W-1:0]    dramDin,
  input  logic [DATA_W-1:0]    dramDout
);

  localparam int ROWS         = 1 << PIN_W;
  localparam int REF_INTERVAL = REF_WINDOW_CYC / ROWS;

  dramStrobe_t      strobes;
  logic [PIN_W-1:0] refRow;

  dram_ctrl_fsm #(
    .PIN_W(PIN_W), .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .REF_INTERVAL(REF_INTERVAL)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqAddr[2*PIN_W-1:PIN_W]), .reqReady(reqReady),
    .strobes(strobes), .refRow(refRow)
  );

  dram_ctrl_datapath #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .T_PRE(T_PRE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .refRow(refRow), .dramDout(dramDout),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramAddr(dramAddr), .dramDin(dramDin), .rspValid(rspValid),
    .rspData(rspData)
  );

endmodule

// File: tb/test_dram_page_ctrl.sv
`timescale 1ns/100ps
module test_dram_page_ctrl;

  localparam int PIN_W  = 8;
  localparam int DATA_W = 8;
  localparam int T_PRE  = 2;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int ROWS   = 1 << PIN_W;
  localparam int REF_IV = 150;
  localparam int LAT_HIT    = T_CAS + 2;
  localparam int LAT_CLOSED = T_RCD + T_CAS + 2;
  localparam int LAT_MISS   = T_PRE + T_RCD + T_CAS + 2;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic reqReady, rspValid;
  logic [2*PIN_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0]  reqWdata = '0, rspData;
  logic dramRasN, dramCasN, dramWeN;
  logic [PIN_W-1:0]  dramAddr;
  logic [DATA_W-1:0] dramDin;
  logic [DATA_W-1:0] dramDout = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_page_ctrl #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .T_PRE(T_PRE), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .REF_WINDOW_CYC(REF_IV * ROWS)
  ) i_dram_page_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramAddr(dramAddr),
    .dramDin(dramDin), .dramDout(dramDout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural device stub ----------------
  logic [DATA_W-1:0] mem [int];
  logic [PIN_W-1:0]  stubRow = '0, stubCol = '0;

  always @(negedge dramRasN) begin
    #0.2;
    stubRow = dramAddr;
  end

  always @(negedge dramCasN) begin
    #0.2;
    stubCol = dramAddr;
    if (!dramWeN) mem[int'({stubRow, stubCol})] = dramDin;
    else dramDout = mem.exists(int'({stubRow, stubCol})) ? mem[int'({stubRow, stubCol})] : '0;
  end

  // ---------------- pin monitor ----------------
  int  cyc = 0;
  bit  prevRas = 1, prevCas = 1, sawCas = 0, firstFall = 1, sawWrap = 0;
  int  rasHighRun = 100, rasLowRun = 0, casLowRun = 0;
  int  refCount = 0, rasFalls = 0, lastRefCyc = 0;
  logic [PIN_W-1:0] rowAtFall = '0, expRef = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevRas && !dramRasN) begin
        if (!firstFall) check(rasHighRun >= T_PRE, "R6 precharge gap", rasHighRun, T_PRE);
        firstFall = 0;
        rasFalls++;
        rowAtFall = dramAddr;
        sawCas = 0;
      end
      if (prevCas && !dramCasN) begin
        check(!dramRasN, "R3 cas while ras low", dramRasN, 0);
        if (!sawCas) check(rasLowRun >= T_RCD, "R3 ras-to-cas", rasLowRun, T_RCD);
        sawCas = 1;
      end
      if (!prevCas && dramCasN) check(casLowRun == T_CAS, "R3 cas width", casLowRun, T_CAS);
      if (!dramWeN) check(!dramCasN, "R4 we outside cas", dramCasN, 0);
      if (!prevRas && dramRasN && !sawCas) begin
        check(rowAtFall == expRef, "R9 refresh row", rowAtFall, expRef);
        check(rasLowRun == T_RCD + T_CAS, "R8 refresh ras width", rasLowRun, T_RCD + T_CAS);
        check(dramCasN, "R8 refresh cas high", dramCasN, 1);
        if (expRef == '0 && refCount > 0) sawWrap = 1;
        expRef = expRef + 1'b1;
        refCount++;
        lastRefCyc = cyc;
      end
      rasHighRun = dramRasN ? (prevRas ? rasHighRun + 1 : 1) : 0;
      rasLowRun  = !dramRasN ? (!prevRas ? rasLowRun + 1 : 1) : 0;
      casLowRun  = !dramCasN ? (!prevCas ? casLowRun + 1 : 1) : 0;
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  // ---------------- access tasks ----------------
  task automatic access(input bit wr, input logic [2*PIN_W-1:0] a,
                        input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q,
                        output int lat);
    int guard = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 0;
    check(!reqReady, "R7 ready low after accept", reqReady, 0);
    lat = 1;
    if (wr) begin
      while (!reqReady && lat < 100) begin @(negedge clk); lat++; end
      q = '0;
    end else begin
      while (!rspValid && lat < 100) begin @(negedge clk); lat++; end
      q = rspData;
    end
  endtask

  task automatic wait_refresh();
    int n = refCount;
    while (refCount == n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN, "R1 strobes high in reset",
          {dramRasN, dramCasN, dramWeN}, 3'b111);
    rstN = 1;
    @(negedge clk);
    check(dramRasN && dramCasN && dramWeN, "R1 strobes high after reset",
          {dramRasN, dramCasN, dramWeN}, 3'b111);
    check(!rspValid, "R1 rspValid low", rspValid, 0);
    check(reqReady, "R1 ready high", reqReady, 1);
  endtask

  task automatic t_write_read();
    logic [DATA_W-1:0] q; int lat;
    wait_refresh();
    access(1, 16'h1234, 8'hA5, q, lat);
    check(lat == LAT_CLOSED, "R7 write completes, closed row", lat, LAT_CLOSED);
    check(mem.exists(int'(16'h1234)) && mem[int'(16'h1234)] == 8'hA5, "R4 write stored",
          mem.exists(int'(16'h1234)) ? mem[int'(16'h1234)] : 0, 8'hA5);
    check(stubRow == 8'h12 && stubCol == 8'h34, "R2 row/col split", {stubRow, stubCol}, 16'h1234);
    access(0, 16'h1234, 8'h00, q, lat);
    check(q == 8'hA5, "R4 read data", q, 8'hA5);
    check(lat == LAT_HIT, "R5 hit latency", lat, LAT_HIT);
  endtask

  task automatic t_page_burst();
    logic [DATA_W-1:0] q; int lat; int falls;
    wait_refresh();
    access(0, 16'h1234, 8'h00, q, lat);
    check(lat == LAT_CLOSED, "R10 closed after refresh", lat, LAT_CLOSED);
    falls = rasFalls;
    for (int i = 0; i < 4; i++) access(1, 16'h1238 + 16'(i), 8'h50 + 8'(i), q, lat);
    for (int i = 0; i < 4; i++) begin
      access(0, 16'h1238 + 16'(i), 8'h00, q, lat);
      check(q == 8'h50 + 8'(i), "R5 burst data", q, 8'h50 + 8'(i));
      check(lat == LAT_HIT, "R5 burst hit latency", lat, LAT_HIT);
    end
    check(rasFalls == falls, "R5 ras held across burst", rasFalls, falls);
  endtask

  task automatic t_row_miss();
    logic [DATA_W-1:0] q; int lat;
    wait_refresh();
    access(0, 16'h1234, 8'h00, q, lat);
    access(1, 16'h3412, 8'h77, q, lat);
    check(lat == LAT_MISS, "R6 miss write latency", lat, LAT_MISS);
    access(0, 16'h1234, 8'h00, q, lat);
    check(q == 8'hA5, "R2 swapped halves distinct", q, 8'hA5);
    check(lat == LAT_MISS, "R6 miss read latency", lat, LAT_MISS);
    access(0, 16'h3412, 8'h00, q, lat);
    check(q == 8'h77, "R2 read other row", q, 8'h77);
    check(stubRow == 8'h34 && stubCol == 8'h12, "R2 pins for 3412", {stubRow, stubCol}, 16'h3412);
  endtask

  task automatic t_refresh_interval();
    int c1, c2, n;
    wait_refresh();
    wait_refresh();
    c1 = lastRefCyc;
    wait_refresh();
    c2 = lastRefCyc;
    check(c2 - c1 == REF_IV, "R8 refresh interval", c2 - c1, REF_IV);
    n = 0;
    while (reqReady && n < 400) begin @(negedge clk); n++; end
    check(!reqReady, "R7 ready low while refresh due", reqReady, 0);
  endtask

  task automatic t_refresh_wrap();
    int start = refCount;
    while (refCount < start + ROWS + 4) @(negedge clk);
    check(sawWrap, "R9 refresh row wraps", sawWrap, 1);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_page_burst();
    t_row_miss();
    t_refresh_interval();
    t_refresh_wrap();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule